// File: doc/BRIEF.md
# Three-Leg Phase-Shifted Triangle Modulator

This block turns one shared triangular carrier into switch commands for three half-bridge legs. Each leg has a top and a bottom gate output. In modulation mode, each leg compares a latched duty value against its own copy of the carrier. That copy is delayed by a per-leg fraction of the carrier period, so interleaved or phase-displaced switching needs no second counter. The carrier is an input from outside the block. The block only needs the carrier value, its peak, and one-cycle flags at the minimum and the maximum.

New duty references and new shifts are taken at a selectable carrier event: the minimum, the maximum, or both. Taking them at both extremes gives asymmetric regular sampling. The duty can come from a register-side input or from a fabric-side input. Two paths sit beside the modulator. A switching-state mode drives the gates directly from applied states. A per-leg tristate bit forces both switches of a leg off. Dead time and interlock belong to a later stage.

Top module: `pwm3_shifted_carrier`

## Requirements
- R1: While rst_ni is low, every top and bottom gate output is 0.
- R2: A leg whose tristate_i bit is 1 has both gate outputs at 0 one cycle later, in either mode.
- R3: With mode_ss_i = 1, gate_top_o and gate_bot_o of each non-tristate leg equal ss_top_i and ss_bot_i of the previous cycle.
- R4: With mode_ss_i = 0, a non-tristate leg's top gate is 1 exactly when its latched compare value is strictly greater than its shifted carrier in the previous cycle, and the bottom gate is the inverse of the top gate.
- R5: Duty compare values and shifts are loaded only in a cycle carrying the selected event: trig_sel_i = 0 selects at_min_i, 1 selects at_max_i, and 2 or 3 selects either flag. They are used from the next cycle on, and input changes in any other cycle have no effect.
- R6: src_fabric_i = 1 loads duty from duty_fab_i, and src_fabric_i = 0 loads it from duty_reg_i. Each leg k uses bits [k*DW +: DW].
- R7: Duty is signed with 1.0 = 2^(DW-2) (16384 at DW = 16). Negative values clamp to 0, and values above 1.0 clamp to 1.0. The compare value is floor(duty_clamped * peak_i / 2^(DW-2)).
- R8: Shift s (SW bits, fraction s/2^SW of the period) makes leg k use the base triangle as it stood floor(s*2*peak/2^SW) cycles earlier. That is the triangle evaluated at phase (p - offset) mod 2*peak and folded back about peak. Reset state is shift 0 and compare value 0.
- R9: The carrier phase p equals carrier_i while rising and 2*peak - carrier_i while falling. The direction becomes rising at at_min_i, becomes falling at at_max_i, and is rising after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| carrier_i | input | CW | Shared triangle value |
| peak_i | input | CW | Triangle maximum |
| at_min_i | input | 1 | Carrier at minimum this cycle |
| at_max_i | input | 1 | Carrier at maximum this cycle |
| mode_ss_i | input | 1 | 1 = direct switching states, 0 = modulation |
| src_fabric_i | input | 1 | Duty source select |
| trig_sel_i | input | 2 | Load event select |
| duty_reg_i | input | NLEG*DW | Register-side duties, signed |
| duty_fab_i | input | NLEG*DW | Fabric-side duties, signed |
| shift_i | input | NLEG*SW | Per-leg carrier shift fractions |
| ss_top_i | input | NLEG | Direct top switch states |
| ss_bot_i | input | NLEG | Direct bottom switch states |
| tristate_i | input | NLEG | Per-leg force-off |
| gate_top_o | output | NLEG | Top switch commands |
| gate_bot_o | output | NLEG | Bottom switch commands |

## Verification
The bench keeps the default NLEG = 3, CW = 12, DW = 16 and SW = 10, and runs a triangle with a peak of 40, so one period is 80 cycles. The short period lets each trigger choice, both extremes and wrap-around shifts of one quarter and one half occur many times in a run. A duty of 1.0 then lands exactly on the peak, which exposes the strict comparison at the top of the carrier. The 14-bit duty fraction leaves room for values above 1.0 and below 0, so both clamp directions can be driven.

// File: rtl/pwm3_pkg.sv
`timescale 1ns/1ps
package pwm3_pkg;
  typedef enum logic [1:0] {
    TRIG_MIN  = 2'd0,
    TRIG_MAX  = 2'd1,
    TRIG_BOTH = 2'd2,
    TRIG_ANY  = 2'd3
  } trig_e;
endpackage

// File: rtl/pwm3_ref_latch.sv
`timescale 1ns/1ps
module pwm3_ref_latch #(
  parameter int CW = 12,
  parameter int DW = 16,
  parameter int SW = 10
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 load_i,
  input  logic [CW-1:0]        peak_i,
  input  logic signed [DW-1:0] duty_i,
  input  logic [SW-1:0]        shift_i,
  output logic [CW-1:0]        cmp_o,
  output logic [SW-1:0]        shift_o
);
  localparam int PW = DW - 1 + CW;
  localparam logic [DW-2:0] ONE = (DW-1)'(1) << (DW-2);

  logic [DW-2:0] duty_c;
  logic [PW-1:0] prod;
  logic [CW-1:0] cmp_d;
  logic          unused_prod;

  always_comb begin
    if (duty_i[DW-1])             duty_c = '0;
    else if (duty_i[DW-2:0] > ONE) duty_c = ONE;
    else                          duty_c = duty_i[DW-2:0];
  end

  assign prod        = {{CW{1'b0}}, duty_c} * {{(DW-1){1'b0}}, peak_i};
  assign cmp_d       = prod[DW-2 +: CW];
  assign unused_prod = ^{prod[PW-1], prod[DW-3:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_o   <= '0;
      shift_o <= '0;
    end else if (load_i) begin
      cmp_o   <= cmp_d;
      shift_o <= shift_i;
    end
  end
endmodule

// File: rtl/pwm3_leg_carrier.sv
`timescale 1ns/1ps
module pwm3_leg_carrier #(
  parameter int CW = 12,
  parameter int SW = 10
) (
  input  logic [CW:0]   phase_i,
  input  logic [CW-1:0] peak_i,
  input  logic [SW-1:0] shift_i,
  output logic [CW-1:0] carrier_o
);
  localparam int PW = SW + CW + 1;

  logic [CW:0]   per2;
  logic [PW-1:0] prod;
  logic [CW:0]   ofs;
  logic [CW:0]   sp;
  logic [CW:0]   fold;
  logic          unused_lo;

  assign per2      = {peak_i, 1'b0};
  assign prod      = {{(CW+1){1'b0}}, shift_i} * {{SW{1'b0}}, per2};
  assign ofs       = prod[SW +: CW+1];
  assign unused_lo = ^prod[SW-1:0];

  // delayed phase, wrapped into [0, 2*peak)
  always_comb begin
    if (phase_i >= ofs) sp = phase_i - ofs;
    else                sp = per2 - (ofs - phase_i);
    fold = (sp <= {1'b0, peak_i}) ? sp : per2 - sp;
  end

  assign carrier_o = fold[CW-1:0];
endmodule

// File: rtl/pwm3_leg_out.sv
`timescale 1ns/1ps
module pwm3_leg_out #(
  parameter int CW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tristate_i,
  input  logic          mode_ss_i,
  input  logic          ss_top_i,
  input  logic          ss_bot_i,
  input  logic [CW-1:0] cmp_i,
  input  logic [CW-1:0] carrier_i,
  output logic          top_o,
  output logic          bot_o
);
  logic pwm_hi;
  assign pwm_hi = cmp_i > carrier_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      top_o <= 1'b0;
      bot_o <= 1'b0;
    end else if (tristate_i) begin
      top_o <= 1'b0;
      bot_o <= 1'b0;
    end else if (mode_ss_i) begin
      top_o <= ss_top_i;
      bot_o <= ss_bot_i;
    end else begin
      top_o <= pwm_hi;
      bot_o <= ~pwm_hi;
    end
  end
endmodule

// File: rtl/pwm3_shifted_carrier.sv
`timescale 1ns/1ps
module pwm3_shifted_carrier
  import pwm3_pkg::*;
#(
  parameter int NLEG = 3,
  parameter int CW   = 12,
  parameter int DW   = 16,
  parameter int SW   = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CW-1:0]     carrier_i,
  input  logic [CW-1:0]     peak_i,
  input  logic              at_min_i,
  input  logic              at_max_i,
  input  logic              mode_ss_i,
  input  logic              src_fabric_i,
  input  logic [1:0]        trig_sel_i,
  input  logic [NLEG*DW-1:0] duty_reg_i,
  input  logic [NLEG*DW-1:0] duty_fab_i,
  input  logic [NLEG*SW-1:0] shift_i,
  input  logic [NLEG-1:0]   ss_top_i,
  input  logic [NLEG-1:0]   ss_bot_i,
  input  logic [NLEG-1:0]   tristate_i,
  output logic [NLEG-1:0]   gate_top_o,
  output logic [NLEG-1:0]   gate_bot_o
);
  logic           dir_up_q;
  logic           up_now;
  logic [CW:0]    phase;
  logic           ref_load;
  trig_e          trig;
  logic [NLEG*CW-1:0] cmp_all;

  // flags override the stored direction in their own cycle
  assign up_now = at_min_i | (~at_max_i & dir_up_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dir_up_q <= 1'b1;
    else         dir_up_q <= up_now;
  end

  assign phase = up_now ? {1'b0, carrier_i} : {peak_i, 1'b0} - {1'b0, carrier_i};

  assign trig = trig_e'(trig_sel_i);
  always_comb begin
    unique case (trig)
      TRIG_MIN: ref_load = at_min_i;
      TRIG_MAX: ref_load = at_max_i;
      default:  ref_load = at_min_i | at_max_i;
    endcase
  end

  for (genvar g = 0; g < NLEG; g++) begin : g_leg
    logic signed [DW-1:0] duty_sel;
    logic [SW-1:0]        shift_q;
    logic [CW-1:0]        cmp_q;
    logic [CW-1:0]        leg_car;

    assign duty_sel = src_fabric_i ? duty_fab_i[g*DW +: DW] : duty_reg_i[g*DW +: DW];

    pwm3_ref_latch #(.CW(CW), .DW(DW), .SW(SW)) u_ref (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .load_i  (ref_load),
      .peak_i  (peak_i),
      .duty_i  (duty_sel),
      .shift_i (shift_i[g*SW +: SW]),
      .cmp_o   (cmp_q),
      .shift_o (shift_q)
    );

    pwm3_leg_carrier #(.CW(CW), .SW(SW)) u_car (
      .phase_i   (phase),
      .peak_i    (peak_i),
      .shift_i   (shift_q),
      .carrier_o (leg_car)
    );

    pwm3_leg_out #(.CW(CW)) u_out (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .tristate_i (tristate_i[g]),
      .mode_ss_i  (mode_ss_i),
      .ss_top_i   (ss_top_i[g]),
      .ss_bot_i   (ss_bot_i[g]),
      .cmp_i      (cmp_q),
      .carrier_i  (leg_car),
      .top_o      (gate_top_o[g]),
      .bot_o      (gate_bot_o[g])
    );

    assign cmp_all[g*CW +: CW] = cmp_q;
  end
endmodule

// File: rtl/pwm3_checker.sv
`timescale 1ns/1ps
module pwm3_checker #(
  parameter int NLEG = 3,
  parameter int CW   = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              at_min_i,
  input logic              at_max_i,
  input logic [1:0]        trig_sel_i,
  input logic              mode_ss_i,
  input logic [NLEG-1:0]   ss_top_i,
  input logic [NLEG-1:0]   tristate_i,
  input logic [NLEG-1:0]   gate_top_o,
  input logic [NLEG-1:0]   gate_bot_o,
  input logic [NLEG*CW-1:0] cmp_all
);
  logic sel_event;
  always_comb begin
    if (trig_sel_i == 2'd0)      sel_event = at_min_i;
    else if (trig_sel_i == 2'd1) sel_event = at_max_i;
    else                         sel_event = at_min_i | at_max_i;
  end

  p_tristate_off_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> ((gate_top_o | gate_bot_o) & $past(tristate_i)) == '0);

  p_ss_follow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(mode_ss_i)) |-> gate_top_o == ($past(ss_top_i) & ~$past(tristate_i)));

  p_complement_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !$past(mode_ss_i)) |-> ((gate_top_o ^ gate_bot_o) | $past(tristate_i)) == '1);

  p_ref_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_event |=> $stable(cmp_all));
endmodule

bind pwm3_shifted_carrier pwm3_checker #(.NLEG(NLEG), .CW(CW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .at_min_i   (at_min_i),
  .at_max_i   (at_max_i),
  .trig_sel_i (trig_sel_i),
  .mode_ss_i  (mode_ss_i),
  .ss_top_i   (ss_top_i),
  .tristate_i (tristate_i),
  .gate_top_o (gate_top_o),
  .gate_bot_o (gate_bot_o),
  .cmp_all    (cmp_all)
);

// File: tb/pwm3_shifted_carrier_bench.sv
`timescale 1ns/1ps
module pwm3_shifted_carrier_bench;
  localparam int NLEG = 3;
  localparam int CW   = 12;
  localparam int DW   = 16;
  localparam int SW   = 10;
  localparam int PEAK = 40;
  localparam int ONE  = 16384;

  typedef struct {
    logic [NLEG-1:0] top;
    logic [NLEG-1:0] bot;
    string           req;
  } exp_t;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [CW-1:0] carrier_i = '0;
  logic [CW-1:0] peak_i = CW'(PEAK);
  logic at_min_i = 1'b0, at_max_i = 1'b0;
  logic mode_ss_i = 1'b0, src_fabric_i = 1'b0;
  logic [1:0] trig_sel_i = 2'd2;
  logic signed [DW-1:0] dreg [NLEG];
  logic signed [DW-1:0] dfab [NLEG];
  logic [SW-1:0] sh [NLEG];
  logic [NLEG-1:0] ss_top_i = '0, ss_bot_i = '0, tristate_i = '0;
  logic [NLEG*DW-1:0] duty_reg_i, duty_fab_i;
  logic [NLEG*SW-1:0] shift_i;
  logic [NLEG-1:0] gate_top_o, gate_bot_o;

  assign duty_reg_i = {dreg[2], dreg[1], dreg[0]};
  assign duty_fab_i = {dfab[2], dfab[1], dfab[0]};
  assign shift_i    = {sh[2], sh[1], sh[0]};

  always #4 clk_i = ~clk_i;

  pwm3_shifted_carrier #(.NLEG(NLEG), .CW(CW), .DW(DW), .SW(SW)) u_pwm3_shifted_carrier (
    .clk_i(clk_i), .rst_ni(rst_ni), .carrier_i(carrier_i), .peak_i(peak_i),
    .at_min_i(at_min_i), .at_max_i(at_max_i), .mode_ss_i(mode_ss_i),
    .src_fabric_i(src_fabric_i), .trig_sel_i(trig_sel_i),
    .duty_reg_i(duty_reg_i), .duty_fab_i(duty_fab_i), .shift_i(shift_i),
    .ss_top_i(ss_top_i), .ss_bot_i(ss_bot_i), .tristate_i(tristate_i),
    .gate_top_o(gate_top_o), .gate_bot_o(gate_bot_o)
  );

  exp_t q[$];
  int n_vec = 0, n_fail = 0;
  int ph = 0;
  int m_cmp [NLEG];
  int m_sh  [NLEG];
  bit m_up = 1'b1;
  bit done = 1'b0;

  // monitor: outputs settle after each rising edge
  initial begin
    forever begin
      @(posedge clk_i);
      #2;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        n_vec++;
        if (gate_top_o !== e.top || gate_bot_o !== e.bot) begin
          n_fail++;
          $display("FAIL %s top/bot actual %b/%b expected %b/%b", e.req,
                   gate_top_o, gate_bot_o, e.top, e.bot);
        end
      end
    end
  end

  function automatic int clamp_duty(int d);
    if (d < 0) return 0;
    if (d > ONE) return ONE;
    return d;
  endfunction

  // driver: applies one cycle, pushes the output expected after the next edge
  task automatic cyc(input string req);
    exp_t e;
    int c, p, ofs, sp, f;
    bit up, ev;
    c = (ph <= PEAK) ? ph : 2*PEAK - ph;
    carrier_i = CW'(c);
    at_min_i  = (c == 0);
    at_max_i  = (c == PEAK);
    up = at_min_i ? 1'b1 : (at_max_i ? 1'b0 : m_up);
    p  = up ? c : 2*PEAK - c;
    e.req = req;
    for (int k = 0; k < NLEG; k++) begin
      if (tristate_i[k]) begin
        e.top[k] = 1'b0; e.bot[k] = 1'b0;
      end else if (mode_ss_i) begin
        e.top[k] = ss_top_i[k]; e.bot[k] = ss_bot_i[k];
      end else begin
        ofs = (m_sh[k] * 2 * PEAK) >> SW;
        sp  = (p >= ofs) ? p - ofs : p + 2*PEAK - ofs;
        f   = (sp <= PEAK) ? sp : 2*PEAK - sp;
        e.top[k] = (m_cmp[k] > f);
        e.bot[k] = ~e.top[k];
      end
    end
    q.push_back(e);
    m_up = up;
    case (trig_sel_i)
      2'd0:    ev = at_min_i;
      2'd1:    ev = at_max_i;
      default: ev = at_min_i | at_max_i;
    endcase
    if (ev) begin
      for (int k = 0; k < NLEG; k++) begin
        m_cmp[k] = (clamp_duty(int'(src_fabric_i ? dfab[k] : dreg[k])) * PEAK) >> 14;
        m_sh[k]  = int'(sh[k]);
      end
    end
    ph = (ph + 1) % (2*PEAK);
    @(negedge clk_i);
  endtask

  task automatic run(input int n, input string req);
    for (int i = 0; i < n; i++) cyc(req);
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
  endtask

  initial begin
    for (int k = 0; k < NLEG; k++) begin
      dreg[k] = '0; dfab[k] = '0; sh[k] = '0; m_cmp[k] = 0; m_sh[k] = 0;
    end
    repeat (3) @(negedge clk_i);
    // R1: reset state
    n_vec++;
    if (gate_top_o !== '0 || gate_bot_o !== '0) begin
      n_fail++;
      $display("FAIL R1 top/bot actual %b/%b expected 000/000", gate_top_o, gate_bot_o);
    end
    rst_ni = 1'b1;

    // R3: direct switching states, R2 tristate override there
    mode_ss_i = 1'b1;
    ss_top_i = 3'b101; ss_bot_i = 3'b010; run(3, "R3");
    ss_top_i = 3'b011; ss_bot_i = 3'b100; run(3, "R3");
    ss_top_i = 3'b111; ss_bot_i = 3'b111; tristate_i = 3'b001; run(3, "R2");
    tristate_i = '0;

    // R4: modulation, half duty, no shift, either-extreme load
    mode_ss_i = 1'b0; trig_sel_i = 2'd2;
    for (int k = 0; k < NLEG; k++) dreg[k] = 16'sd8192;
    run(160, "R4");
    dreg[0] = 16'sd4000; dreg[1] = 16'sd12000; dreg[2] = 16'sd16384;
    run(160, "R4");

    // R8 R9: per-leg shifts 0, 1/4, 1/2 across both slopes
    for (int k = 0; k < NLEG; k++) dreg[k] = 16'sd6000;
    sh[0] = 10'd0; sh[1] = 10'd256; sh[2] = 10'd512;
    run(160, "R8 R9");
    sh[0] = 10'd100; sh[1] = 10'd700; sh[2] = 10'd1023;
    run(160, "R8 R9");

    // R5: min-only and max-only loads, mid-period changes must wait
    trig_sel_i = 2'd0;
    run(30, "R5");
    dreg[0] = 16'sd14000; dreg[1] = 16'sd2000; sh[1] = 10'd300;
    run(100, "R5");
    trig_sel_i = 2'd1;
    run(25, "R5");
    dreg[2] = 16'sd1000; dreg[0] = 16'sd9000;
    run(100, "R5");
    trig_sel_i = 2'd3;
    run(80, "R5");

    // R6: fabric source
    trig_sel_i = 2'd2;
    dfab[0] = 16'sd15000; dfab[1] = 16'sd3000; dfab[2] = 16'sd8000;
    src_fabric_i = 1'b1; run(160, "R6");
    src_fabric_i = 1'b0; run(80, "R6");

    // R7: clamping
    sh[0] = '0; sh[1] = '0; sh[2] = '0;
    dreg[0] = -16'sd5000; dreg[1] = 16'sd20000; dreg[2] = 16'sd16384;
    run(160, "R7");

    // R2: tristate during modulation
    tristate_i = 3'b010; run(80, "R2");
    tristate_i = '0;     run(10, "R2");

    repeat (3) @(negedge clk_i);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog (R1 to R9) actual hung expected completion");
      summary();
      $finish;
    end
  end
endmodule